// File: doc/BRIEF.md
# Paired-Register 32x32 Multiply Unit

This unit runs one multiply instruction of a media extension. From a 32-bit instruction word it takes two general-purpose source register indices, reads their values through two plain read ports, and forms the full 64-bit product of the two 32-bit operands. The operands are treated as either two's complement or unsigned numbers, as the instruction's sub-operation field selects. If either source index is register zero, the product is forced to zero and the operand values are ignored.

The product is registered for one cycle. A one-cycle done pulse then writes the two halves into two entries of a local 16-entry, 32-bit media register file. The upper half goes to one entry and the lower half to another. The same two halves are also loaded into the HI/LO accumulator pair. Media entry 0 is hard-wired to zero. A read port on the register file lets the surrounding pipeline read its contents. Any other sub-operation code belongs to another instruction, and this unit ignores it.

Top module: `pmul_unit`

## Requirements
- R1: Instruction bits 15..14 select the sub-operation. Value 00 is the signed multiply and 01 is the unsigned multiply. An issue with either code is accepted.
- R2: The upper-half destination index is instruction bits 9..6 and the lower-half destination index is bits 13..10. Both are presented on the index outputs while done is high.
- R3: The first source index (instruction bits 20..16) drives src1_idx and the second (bits 25..21) drives src2_idx, combinationally from instr.
- R4: If either source index is 0, both product halves are zero, whatever values the read ports return.
- R5: Product bits 63..32 go to the upper-half destination and to HI. Bits 31..0 go to the lower-half destination and to LO.
- R6: The signed form multiplies two's complement operands and the unsigned form multiplies unsigned operands, giving the exact 64-bit result.
- R7: done is high for exactly the one cycle after an accepted issue. xr_hi_we, xr_lo_we, hi_we and lo_we all equal done. HI/LO and the register file take the new values at the edge that ends the done cycle.
- R8: If both destination indices are equal, that entry ends up holding the lower half.
- R9: Writes to media entry 0 are dropped, so reading entry 0 always returns zero.
- R10: An issue with sub-operation code 10 or 11 produces no done pulse and changes neither HI/LO nor the register file.
- R11: After reset, done is low, HI and LO are zero and every media entry reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src1_idx | output | 5 | First source register read address |
| src1_val | input | 32 | First source register value |
| src2_idx | output | 5 | Second source register read address |
| src2_val | input | 32 | Second source register value |
| done | output | 1 | Result valid, one-cycle pulse |
| xr_hi_we | output | 1 | Write strobe for the upper-half media destination |
| xr_hi_idx | output | 4 | Upper-half media destination index |
| xr_hi_data | output | 32 | Upper product half |
| xr_lo_we | output | 1 | Write strobe for the lower-half media destination |
| xr_lo_idx | output | 4 | Lower-half media destination index |
| xr_lo_data | output | 32 | Lower product half |
| hi_we | output | 1 | HI load strobe |
| lo_we | output | 1 | LO load strobe |
| hi_q | output | 32 | HI accumulator |
| lo_q | output | 32 | LO accumulator |
| xr_rd_idx | input | 4 | Media register file read address |
| xr_rd_data | output | 32 | Media register file read data |

## Verification
The bench puts non-zero values in general register 0 on purpose. A design that reads operands instead of short-circuiting an index of zero then returns a non-zero product. Directed operands of 0x80000000 and 0xFFFFFFFF in both sign modes catch a multiplier that sign-extends in the wrong mode or truncates the upper half. Equal destination indices and destination 0 expose a write order that lets the upper half win, or an entry 0 that keeps data. Sub-operation codes 10 and 11 are issued between legal ones, so a decoder that looks at only one opcode bit produces a spurious done and corrupts HI/LO.

// File: rtl/pmul_unit.sv
module pmul_unit #(
  parameter int DW   = 32,
  parameter int XR_N = 16,
  parameter int XIW  = $clog2(XR_N),
  parameter int GIW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  input  logic [31:0]    instr,
  output logic [GIW-1:0] src1_idx,
  input  logic [DW-1:0]  src1_val,
  output logic [GIW-1:0] src2_idx,
  input  logic [DW-1:0]  src2_val,
  output logic           done,
  output logic           xr_hi_we,
  output logic [XIW-1:0] xr_hi_idx,
  output logic [DW-1:0]  xr_hi_data,
  output logic           xr_lo_we,
  output logic [XIW-1:0] xr_lo_idx,
  output logic [DW-1:0]  xr_lo_data,
  output logic           hi_we,
  output logic           lo_we,
  output logic [DW-1:0]  hi_q,
  output logic [DW-1:0]  lo_q,
  input  logic [XIW-1:0] xr_rd_idx,
  output logic [DW-1:0]  xr_rd_data
);
  localparam int PW        = 2 * DW;
  localparam int HI_IDX_LSB = 6;
  localparam int LO_IDX_LSB = HI_IDX_LSB + XIW;
  localparam int SUB_LSB    = 14;
  localparam int S1_LSB     = 16;
  localparam int S2_LSB     = S1_LSB + GIW;

  logic [1:0] sub_op;
  logic       legal, go, zero_src, sgn;
  logic signed [PW+1:0] prod_full;
  logic [PW-1:0] prod_q;
  logic [XIW-1:0] hi_idx_q, lo_idx_q;
  logic [DW-1:0] xr [XR_N];

  assign sub_op   = instr[SUB_LSB +: 2];
  assign legal    = (sub_op[1] == 1'b0);
  assign sgn      = (sub_op[0] == 1'b0);
  assign go       = issue_valid && legal;
  assign src1_idx = instr[S1_LSB +: GIW];
  assign src2_idx = instr[S2_LSB +: GIW];
  assign zero_src = (src1_idx == '0) || (src2_idx == '0);

  assign prod_full = $signed({sgn & src1_val[DW-1], src1_val}) *
                     $signed({sgn & src2_val[DW-1], src2_val});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      prod_q   <= '0;
      hi_idx_q <= '0;
      lo_idx_q <= '0;
    end else begin
      done <= go;
      if (go) begin
        prod_q   <= zero_src ? '0 : prod_full[PW-1:0];
        hi_idx_q <= instr[HI_IDX_LSB +: XIW];
        lo_idx_q <= instr[LO_IDX_LSB +: XIW];
      end
    end
  end

  assign xr_hi_we   = done;
  assign xr_lo_we   = done;
  assign hi_we      = done;
  assign lo_we      = done;
  assign xr_hi_idx  = hi_idx_q;
  assign xr_lo_idx  = lo_idx_q;
  assign xr_hi_data = prod_q[PW-1:DW];
  assign xr_lo_data = prod_q[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= xr_hi_data;
      if (lo_we) lo_q <= xr_lo_data;
    end
  end

  assign xr[0] = '0;
  for (genvar i = 1; i < XR_N; i++) begin : g_xr
    always_ff @(posedge clk) begin
      if (!rst_n)
        xr[i] <= '0;
      else if (xr_lo_we && xr_lo_idx == XIW'(i))
        xr[i] <= xr_lo_data;
      else if (xr_hi_we && xr_hi_idx == XIW'(i))
        xr[i] <= xr_hi_data;
    end
  end

  assign xr_rd_data = xr[xr_rd_idx];

  assert_done_after_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(issue_valid));
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && legal && (instr[S1_LSB +: GIW] == '0 || instr[S2_LSB +: GIW] == '0))
      |=> (xr_hi_data == '0 && xr_lo_data == '0));
  assert_hilo_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (hi_q == $past(xr_hi_data) && lo_q == $past(xr_lo_data)));
  assert_other_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr[SUB_LSB+1]) |=> !done);
  assert_lo_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && xr_hi_idx == xr_lo_idx && xr_lo_idx != '0) |=>
      (xr[$past(xr_lo_idx)] == $past(xr_lo_data)));
  always_comb begin
    if (rst_n) assert_entry0_zero_R9: assert (xr_rd_idx != '0 || xr_rd_data == '0);
  end
endmodule

// File: tb/pmul_unit_bench.sv
`timescale 1ns/1ps
module pmul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  src1_idx, src2_idx;
  logic [31:0] src1_val, src2_val;
  logic        done, xr_hi_we, xr_lo_we, hi_we, lo_we;
  logic [3:0]  xr_hi_idx, xr_lo_idx;
  logic [31:0] xr_hi_data, xr_lo_data, hi_q, lo_q, xr_rd_data;
  logic [3:0]  xr_rd_idx = '0;

  logic [31:0] gpr [32];
  logic [31:0] m_xr [16];
  logic [31:0] m_hi, m_lo;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign src1_val = gpr[src1_idx];
  assign src2_val = gpr[src2_idx];

  pmul_unit u_pmul_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .src1_idx(src1_idx), .src1_val(src1_val), .src2_idx(src2_idx), .src2_val(src2_val),
    .done(done), .xr_hi_we(xr_hi_we), .xr_hi_idx(xr_hi_idx), .xr_hi_data(xr_hi_data),
    .xr_lo_we(xr_lo_we), .xr_lo_idx(xr_lo_idx), .xr_lo_data(xr_lo_data),
    .hi_we(hi_we), .lo_we(lo_we), .hi_q(hi_q), .lo_q(lo_q),
    .xr_rd_idx(xr_rd_idx), .xr_rd_data(xr_rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input bit is_signed, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    ea = is_signed ? {{32{a[31]}}, a} : {32'd0, a};
    eb = is_signed ? {{32{b[31]}}, b} : {32'd0, b};
    return ea * eb;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] s1, input logic [4:0] s2,
                                     input logic [3:0] dh, input logic [3:0] dl);
    logic [31:0] w;
    w = $urandom;
    w[25:21] = s2; w[20:16] = s1; w[15:14] = op; w[13:10] = dl; w[9:6] = dh;
    return w;
  endfunction

  task automatic read_xr(input logic [3:0] idx, input string tag);
    xr_rd_idx = idx;
    #1;
    chk(xr_rd_data == m_xr[idx], tag, {32'd0, xr_rd_data}, {32'd0, m_xr[idx]});
  endtask

  task automatic run(input logic [31:0] w);
    logic [63:0] exp;
    bit legal;
    legal = (w[15] == 1'b0);
    exp = (w[20:16] == 0 || w[25:21] == 0) ? 64'd0 : ref_mul(w[14] == 1'b0, gpr[w[20:16]], gpr[w[25:21]]);
    @(negedge clk);
    issue_valid = 1'b1; instr = w;
    #1;
    chk(src1_idx == w[20:16] && src2_idx == w[25:21], "R3 source index decode",
        {54'd0, src1_idx, src2_idx}, {54'd0, w[20:16], w[25:21]});
    @(negedge clk);
    issue_valid = 1'b0; instr = $urandom;
    if (legal) begin
      chk(done && xr_hi_we && xr_lo_we && hi_we && lo_we, "R7 done and strobes",
          {59'd0, done, xr_hi_we, xr_lo_we, hi_we, lo_we}, 64'h1f);
      chk(xr_hi_idx == w[9:6] && xr_lo_idx == w[13:10], "R2 destination indices",
          {56'd0, xr_hi_idx, xr_lo_idx}, {56'd0, w[9:6], w[13:10]});
      chk({xr_hi_data, xr_lo_data} == exp,
          (exp == 0) ? "R4/R6 product (zero case)" : (w[14] ? "R1 R6 unsigned product" : "R1 R6 signed product"),
          {xr_hi_data, xr_lo_data}, exp);
      if (w[9:6] != 0) m_xr[w[9:6]] = exp[63:32];
      if (w[13:10] != 0) m_xr[w[13:10]] = exp[31:0];
      m_hi = exp[63:32]; m_lo = exp[31:0];
    end else begin
      chk(!done && !xr_hi_we && !xr_lo_we && !hi_we && !lo_we, "R10 other sub-op ignored",
          {63'd0, done}, 64'd0);
    end
    @(negedge clk);
    chk(hi_q == m_hi && lo_q == m_lo, "R5 HI/LO contents", {hi_q, lo_q}, {m_hi, m_lo});
    read_xr(w[9:6], "R5 R8 R9 upper destination entry");
    read_xr(w[13:10], "R5 R8 R9 lower destination entry");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) gpr[i] = $urandom;
    gpr[0] = 32'hDEAD_BEEF;
    for (int i = 0; i < 16; i++) m_xr[i] = '0;
    m_hi = '0; m_lo = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && hi_q == 0 && lo_q == 0, "R11 reset outputs", {hi_q, lo_q}, 64'd0);
    for (int i = 0; i < 16; i++) read_xr(4'(i), "R11 reset register file");

    gpr[1] = 32'h8000_0000; gpr[2] = 32'hFFFF_FFFF; gpr[3] = 32'h0000_0007;
    run(mk(2'b00, 5'd1, 5'd1, 4'd1, 4'd2));
    run(mk(2'b01, 5'd1, 5'd1, 4'd3, 4'd4));
    run(mk(2'b00, 5'd2, 5'd2, 4'd5, 4'd6));
    run(mk(2'b01, 5'd2, 5'd2, 4'd7, 4'd8));
    run(mk(2'b00, 5'd2, 5'd3, 4'd9, 4'd10));
    run(mk(2'b00, 5'd0, 5'd0, 4'd1, 4'd2));
    run(mk(2'b01, 5'd3, 5'd0, 4'd3, 4'd4));
    run(mk(2'b00, 5'd0, 5'd2, 4'd5, 4'd6));
    run(mk(2'b00, 5'd2, 5'd3, 4'd11, 4'd11));
    run(mk(2'b01, 5'd1, 5'd2, 4'd0, 4'd12));
    run(mk(2'b00, 5'd1, 5'd2, 4'd13, 4'd0));
    run(mk(2'b00, 5'd2, 5'd2, 4'd0, 4'd0));
    run(mk(2'b10, 5'd1, 5'd2, 4'd14, 4'd15));
    run(mk(2'b11, 5'd2, 5'd3, 4'd14, 4'd15));

    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      if (k % 16 == 0) gpr[$urandom_range(1, 31)] = $urandom;
      run(mk(op, ($urandom_range(0, 9) == 0) ? 5'd0 : 5'($urandom),
                 ($urandom_range(0, 9) == 0) ? 5'd0 : 5'($urandom),
                 4'($urandom), 4'($urandom)));
    end
    for (int i = 0; i < 16; i++) read_xr(4'(i), "R8 R9 final register file");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule